// File: doc/BRIEF.md
# Dual-LUT Configurable Logic Cell

This block is a soft model of a coarse-grained configurable logic cell. Two independent groups of four inputs each address their own 16-entry lookup table, so each group can realise any Boolean function of its four inputs. A second-level 8-entry table combines the two first-level results with one extra direct input. Each of the two cell outputs picks one of the three table results and presents it either straight through or through its own flip-flop.

All table contents and output selections live in a volatile configuration register that is loaded serially. A system first holds the cell in reset, then shifts the full configuration in with the load enable high, and then pulses the ready input. Until that pulse both outputs stay at zero. Starting a new load takes the cell out of the ready state again.

Top module: `cfg_logic_cell`

## Requirements
- R1: After a synchronous reset the configuration register holds all zeros, the ready flag is clear and both outputs are 0, so the cell must be reloaded before use.
- R2: While `load_en` is high, each rising clock edge shifts `load_bit` into the configuration register. The full load is 46 bits, most significant bit first, in this order: first-level table A entries 15 down to 0, first-level table B entries 15 down to 0, combining table entries 7 down to 0, then for output 0 and then output 1 a 3-bit field {source[1:0], registered}.
- R3: The first-level result A equals entry `a_in` of table A, and result B equals entry `b_in` of table B, for every input value.
- R4: The combining result equals entry {`x_in`, result B, result A} of the combining table, with `x_in` as the most significant index bit.
- R5: The source field selects table A with 0, table B with 1, the combining table with 2, and a constant 0 with 3.
- R6: With the registered bit at 0 an output shows the selected value in the same cycle; with it at 1 the output shows that output's flip-flop.
- R7: Each output flip-flop captures the selected value on a rising clock edge when `clk_en` is high and holds its value when `clk_en` is low.
- R8: A synchronous reset clears both output flip-flops; the cleared value is still visible after a following reload done with `clk_en` low.
- R9: A one-cycle pulse on `load_done` with `load_en` low sets the ready flag; while the flag is clear both outputs are 0, and any cycle with `load_en` high clears it.
- R10: While `load_en` is low the configuration register keeps its contents and `load_bit` has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| load_en | input | 1 | Shift enable for the configuration register |
| load_bit | input | 1 | Serial configuration data |
| load_done | input | 1 | Pulse that marks the configuration as ready |
| clk_en | input | 1 | Capture enable for the output flip-flops |
| a_in | input | 4 | Index for first-level table A |
| b_in | input | 4 | Index for first-level table B |
| x_in | input | 1 | Direct input to the combining table |
| cell_out | output | 2 | Cell outputs, bit 0 is output 0 |

## Verification
The embedded assertions watch, on every clock, that the output flip-flops capture or hold according to the capture enable, that outputs stay at zero while the ready flag is clear, that a load cycle clears the ready flag and a ready pulse sets it, and that the configuration register is frozen outside a load. Whether the table contents land in the right positions, whether each lookup and the combining index are wired in the documented order, and whether the source encoding is correct can only be shown by the bench, which loads fixed and random configurations and compares both outputs against an independent model over all 512 input patterns, while also toggling the serial input and capture enable. Reset clearing the flip-flops is shown only by a directed reload scenario.

// File: rtl/clc_pkg.sv
package clc_pkg;

   // Output source encoding (R5)
   typedef enum logic [1:0] {
      SRC_A   = 2'd0,
      SRC_B   = 2'd1,
      SRC_MIX = 2'd2,
      SRC_OFF = 2'd3
   } src_e;

   // Per-output selection field, shifted in as {source, registered}
   typedef struct packed {
      src_e src;
      logic use_ff;
   } osel_t;

   localparam int OSEL_W = $bits(osel_t);
   localparam int MIX_K  = 3;

endpackage

// File: rtl/clc_lut.sv
module clc_lut #(
   parameter int K = 4,
   localparam int DEPTH = 1 << K
) (
   input  logic [DEPTH-1:0] table_bits,
   input  logic [K-1:0]     idx,
   output logic             y
);

   if (K < 1 || K > 8) begin : g_bad_k
      $error("clc_lut: K must be between 1 and 8");
   end

   always_comb begin
      y = table_bits[idx];
   end

endmodule

// File: rtl/clc_cfg_chain.sv
module clc_cfg_chain #(
   parameter int W = 46
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load_en,
   input  logic         load_bit,
   input  logic         load_done,
   output logic [W-1:0] cfg,
   output logic         ready
);

   if (W < 2) begin : g_bad_w
      $error("clc_cfg_chain: W must be at least 2");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cfg <= '0;
      end else if (load_en) begin
         cfg <= {cfg[W-2:0], load_bit};
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ready <= 1'b0;
      end else if (load_en) begin
         ready <= 1'b0;
      end else if (load_done) begin
         ready <= 1'b1;
      end
   end

   AST_LOAD_CLEARS_READY: assert property (@(posedge clk) disable iff (rst)
      load_en |=> !ready);                                               // R9
   AST_DONE_SETS_READY: assert property (@(posedge clk) disable iff (rst)
      (load_done && !load_en) |=> ready);                                // R9
   AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
      !load_en |=> $stable(cfg));                                        // R10
   AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (rst)
      load_en |=> (cfg[0] == $past(load_bit)));                          // R2

endmodule

// File: rtl/clc_out_stage.sv
module clc_out_stage
   import clc_pkg::*;
(
   input  logic  clk,
   input  logic  rst,
   input  logic  clk_en,
   input  logic  ready,
   input  osel_t sel,
   input  logic  res_a,
   input  logic  res_b,
   input  logic  res_mix,
   output logic  y
);

   logic pick;
   logic ff_q;

   always_comb begin
      unique case (sel.src)
         SRC_A:   pick = res_a;
         SRC_B:   pick = res_b;
         SRC_MIX: pick = res_mix;
         default: pick = 1'b0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         ff_q <= 1'b0;
      end else if (clk_en) begin
         ff_q <= pick;
      end
   end

   always_comb begin
      y = ready & (sel.use_ff ? ff_q : pick);
   end

   AST_FF_HOLD: assert property (@(posedge clk) disable iff (rst)
      !clk_en |=> $stable(ff_q));                                        // R7
   AST_FF_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      clk_en |=> (ff_q == $past(pick)));                                 // R7
   AST_GATED_ZERO: assert property (@(posedge clk) disable iff (rst)
      !ready |-> !y);                                                    // R9
   AST_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
      (sel.src == SRC_OFF && !sel.use_ff) |-> !y);                       // R5

endmodule

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell
   import clc_pkg::*;
#(
   parameter int K       = 4,
   parameter int NUM_OUT = 2
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               load_en,
   input  logic               load_bit,
   input  logic               load_done,
   input  logic               clk_en,
   input  logic [K-1:0]       a_in,
   input  logic [K-1:0]       b_in,
   input  logic               x_in,
   output logic [NUM_OUT-1:0] cell_out
);

   localparam int LUT_D  = 1 << K;
   localparam int MIX_D  = 1 << MIX_K;
   localparam int SEL_W  = NUM_OUT * OSEL_W;
   localparam int CFG_W  = 2 * LUT_D + MIX_D + SEL_W;
   localparam int A_LO   = LUT_D + MIX_D + SEL_W;
   localparam int B_LO   = MIX_D + SEL_W;
   localparam int MIX_LO = SEL_W;

   if (NUM_OUT < 1 || NUM_OUT > 8) begin : g_bad_out
      $error("cfg_logic_cell: NUM_OUT must be between 1 and 8");
   end

   logic [CFG_W-1:0] cfg;
   logic             ready;
   logic             res_a;
   logic             res_b;
   logic             res_mix;
   logic [MIX_K-1:0] mix_idx;

   clc_cfg_chain #(.W(CFG_W)) u_chain (
      .clk       (clk),
      .rst       (rst),
      .load_en   (load_en),
      .load_bit  (load_bit),
      .load_done (load_done),
      .cfg       (cfg),
      .ready     (ready)
   );

   clc_lut #(.K(K)) u_lut_a (
      .table_bits (cfg[A_LO +: LUT_D]),
      .idx        (a_in),
      .y          (res_a)
   );

   clc_lut #(.K(K)) u_lut_b (
      .table_bits (cfg[B_LO +: LUT_D]),
      .idx        (b_in),
      .y          (res_b)
   );

   always_comb begin
      mix_idx = {x_in, res_b, res_a};
   end

   clc_lut #(.K(MIX_K)) u_lut_mix (
      .table_bits (cfg[MIX_LO +: MIX_D]),
      .idx        (mix_idx),
      .y          (res_mix)
   );

   for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
      osel_t sel_o;
      always_comb begin
         sel_o = osel_t'(cfg[(NUM_OUT-1-o)*OSEL_W +: OSEL_W]);
      end
      clc_out_stage u_stage (
         .clk     (clk),
         .rst     (rst),
         .clk_en  (clk_en),
         .ready   (ready),
         .sel     (sel_o),
         .res_a   (res_a),
         .res_b   (res_b),
         .res_mix (res_mix),
         .y       (cell_out[o])
      );
   end

   AST_NOT_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
      !ready |-> (cell_out == '0));                                      // R1

endmodule

// File: tb/cfg_logic_cell_bench.sv
module cfg_logic_cell_bench;

   localparam int CW = 46;

   // Fixed configurations: {A, B, MIX, out0 {src,ff}, out1 {src,ff}}
   localparam logic [CW-1:0] CFG_TAB [4] = '{
      {16'h8000, 16'h6996, 8'hE8, 3'b100, 3'b001},
      {16'hFFFE, 16'h0001, 8'h96, 3'b011, 3'b101},
      {16'hA5C3, 16'h3C5A, 8'h1B, 3'b110, 3'b010},
      {16'h1234, 16'hFEDC, 8'h7F, 3'b000, 3'b111}
   };

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       load_en = 1'b0;
   logic       load_bit = 1'b0;
   logic       load_done = 1'b0;
   logic       clk_en = 1'b0;
   logic [3:0] a_in = '0;
   logic [3:0] b_in = '0;
   logic       x_in = 1'b0;
   logic [1:0] cell_out;

   int errors = 0;
   int checks = 0;
   int cycles = 0;

   always #10 clk = ~clk;

   cfg_logic_cell u_cfg_logic_cell (
      .clk       (clk),
      .rst       (rst),
      .load_en   (load_en),
      .load_bit  (load_bit),
      .load_done (load_done),
      .clk_en    (clk_en),
      .a_in      (a_in),
      .b_in      (b_in),
      .x_in      (x_in),
      .cell_out  (cell_out)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 200000) begin
         errors = errors + 1;
         $display("FAIL watchdog: run did not finish");
         $display("Result: errors=%0d of %0d checks", errors, checks + 1);
         $finish;
      end
   end

   task automatic check(input logic got, input logic exp, input string req);
      checks = checks + 1;
      if (got !== exp) begin
         errors = errors + 1;
         $display("FAIL %s: got %0b expected %0b", req, got, exp);
      end
   endtask

   // Model of the selected value for output o (R3, R4, R5)
   function automatic logic ref_pick(input logic [CW-1:0] c, input int o,
                                     input logic [3:0] a, input logic [3:0] b,
                                     input logic x);
      logic ra, rb, rm;
      logic [2:0] s;
      ra = c[30 + a];
      rb = c[14 + b];
      rm = c[6 + {x, rb, ra}];
      s  = c[(1 - o) * 3 +: 3];
      case (s[2:1])
         2'd0:    return ra;
         2'd1:    return rb;
         2'd2:    return rm;
         default: return 1'b0;
      endcase
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
   endtask

   // R2 serial load, most significant bit first
   task automatic load_cfg(input logic [CW-1:0] c, input logic mark_ready);
      @(negedge clk);
      load_en = 1'b1;
      for (int b = CW - 1; b >= 0; b--) begin
         load_bit = c[b];
         @(negedge clk);
      end
      load_en = 1'b0;
      if (mark_ready) begin
         load_done = 1'b1;
         @(negedge clk);
         load_done = 1'b0;
      end
   endtask

   task automatic walk_cfg(input logic [CW-1:0] c);
      logic [1:0] q_model;
      logic [1:0] pk;
      do_reset();
      clk_en = 1'b0;
      load_cfg(c, 1'b1);
      q_model = 2'b00;
      for (int v = 0; v < 512; v++) begin
         @(negedge clk);
         {x_in, b_in, a_in} = v[8:0];
         clk_en   = 1'($urandom);
         load_bit = 1'($urandom);   // R10: ignored while load_en low
         #1;
         for (int o = 0; o < 2; o++) begin
            pk[o] = ref_pick(c, o, a_in, b_in, x_in);
            if (c[(1 - o) * 3] == 1'b1)
               check(cell_out[o], q_model[o], "R6/R7 registered output");
            else
               check(cell_out[o], pk[o], "R3/R4/R5/R6/R10 direct output");
         end
         @(posedge clk);
         if (clk_en) q_model = pk;
      end
   endtask

   initial begin
      logic [63:0] rnd;
      // R1: reset state
      repeat (2) @(negedge clk);
      rst = 1'b0;
      #1;
      check(cell_out[0], 1'b0, "R1 output 0 after reset");
      check(cell_out[1], 1'b0, "R1 output 1 after reset");

      // R9: outputs stay 0 until ready, with A all ones
      clk_en = 1'b1;
      load_cfg({16'hFFFF, 16'h0000, 8'h00, 3'b000, 3'b001}, 1'b0);
      repeat (2) @(negedge clk);
      #1;
      check(cell_out[0], 1'b0, "R9 direct output before ready");
      check(cell_out[1], 1'b0, "R9 registered output before ready");
      load_done = 1'b1;
      @(negedge clk);
      load_done = 1'b0;
      #1;
      check(cell_out[0], 1'b1, "R9 direct output after ready");
      check(cell_out[1], 1'b1, "R9 registered output after ready");
      load_en = 1'b1;
      @(negedge clk);
      load_en = 1'b0;
      #1;
      check(cell_out[0], 1'b0, "R9 load clears ready");

      // R8: reset clears flip-flops, reload with capture disabled
      clk_en = 1'b0;
      do_reset();
      load_cfg({16'hFFFF, 16'h0000, 8'h00, 3'b000, 3'b001}, 1'b1);
      #1;
      check(cell_out[0], 1'b1, "R8 direct output after reload");
      check(cell_out[1], 1'b0, "R8 flip-flop cleared by reset");
      // R7: capture on enable
      clk_en = 1'b1;
      @(negedge clk);
      #1;
      check(cell_out[1], 1'b1, "R7 flip-flop captures with enable");

      // Table walk, then random configurations
      for (int t = 0; t < 4; t++) walk_cfg(CFG_TAB[t]);
      for (int t = 0; t < 4; t++) begin
         rnd = {$urandom(), $urandom()};
         walk_cfg(rnd[CW-1:0]);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule